// File: doc/BRIEF.md
# SDRAM Refresh Scheduler

This block keeps an SDRAM array refreshed. A down-counter is loaded with the number of bus clocks between row refreshes. Software computes that number as the per-row refresh time in nanoseconds times the bus frequency, divided by 1e9. For example, 15625 ns per row at 60 MHz gives 937 clocks. Each time the counter runs out, the block raises a refresh request toward the SDRAM command path and holds it until the request is granted. After the grant, the block keeps a busy flag high for a selectable recovery time, so that no ACTIVE command follows the REF too early.

Software drives the block with command strobes. One command turns periodic refresh on and another turns it off. One command enters self-refresh and another leaves it. Self-refresh acts on every memory block at once. While the memory refreshes itself, requests are withheld and the interval counter is frozen. Leaving self-refresh restarts a full interval. When the module clock enable is low, the block is deinitialised and all of its state is held. Arbitration with normal accesses and driving the SDRAM pins are handled elsewhere. The reset input is asynchronous and active low, and its release is expected to be synchronous to the clock.

Top module: `sdram_refresh_sched`

## Requirements
- R1: After reset, refresh_req, busy and self_ref are low and periodic refresh is off.
- R2: A command with code 4 (refresh on) is taken on a clock edge and loads the counter with cfg_interval = I. The first refresh_req is seen after the (I+2)-th edge counted from that edge. Later requests rise every I+1 cycles.
- R3: refresh_req stays high until it is sampled together with refresh_ack, and it falls on that edge.
- R4: At most one request is outstanding. An interval that expires while a request is pending is dropped and is not queued.
- R5: busy is high while a request is pending. On the grant edge, a recovery count starts, and busy stays high for 3, 6 or 9 more cycles for cfg_recov codes 0, 1 and 2. Code 3 behaves as 9.
- R6: A command with code 5 (refresh off) stops all new requests.
- R7: A command with code 2 raises self_ref on the next edge and withdraws any pending request. No request is made while self_ref is high.
- R8: A command with code 3 clears self_ref and restarts a full interval, so the next request is seen I+2 edges after that command.
- R9: While mod_on is low, all state is held, and commands and grants are ignored. The counter continues where it stopped once mod_on returns high.
- R10: Command codes 0, 1, 6 and 7, and a grant with no pending request, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_on | input | 1 | Module clock enable; low means deinitialised |
| cfg_interval | input | CNT_W | Bus clocks per row refresh (reload value) |
| cfg_recov | input | 2 | Recovery code: 0=3, 1=6, 2/3=9 clocks |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_code | input | 3 | 2 self-refresh enter, 3 exit, 4 refresh on, 5 refresh off |
| refresh_ack | input | 1 | Grant of the refresh request |
| refresh_req | output | 1 | Refresh request, held until granted |
| busy | output | 1 | Request pending or recovery running |
| self_ref | output | 1 | Memory is in self-refresh |

## Verification
The main function is driven from a table that sweeps interval lengths against every recovery code. Each row measures the first-request latency, the steady period and the busy length. These three measurements separate off-by-one errors in the reload from errors in the recovery decode, and the reserved code shows whether it falls back to the longest time. Directed patterns then cover the following cases. A grant is withheld across a second expiry, which shows whether a request was queued twice. A pending request is cut short by self-refresh entry. Gating of the module clock in the middle of an interval shows whether the counter resumes instead of restarting. Unused codes and stray grants show that they are ignored.

// File: rtl/srs_pkg.sv
package srs_pkg;
  localparam logic [2:0] CMD_SR_ENTER = 3'd2;
  localparam logic [2:0] CMD_SR_EXIT  = 3'd3;
  localparam logic [2:0] CMD_AR_ON    = 3'd4;
  localparam logic [2:0] CMD_AR_OFF   = 3'd5;

  // recovery length in bus clocks; code 3 is reserved and maps to the longest
  function automatic int unsigned recov_len(input logic [1:0] code, input int unsigned step);
    case (code)
      2'd0:    recov_len = step;
      2'd1:    recov_len = 2 * step;
      default: recov_len = 3 * step;
    endcase
  endfunction
endpackage

// File: rtl/srs_cmd_decode.sv
module srs_cmd_decode
  import srs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mod_on,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_code,
  output logic       ar_en,
  output logic       self_ref,
  output logic       reload,
  output logic       flush
);
  logic ar_en_q, ar_en_d;
  logic sr_q, sr_d;

  always_comb begin
    ar_en_d = ar_en_q;
    sr_d    = sr_q;
    reload  = 1'b0;
    flush   = 1'b0;
    if (mod_on && cmd_valid) begin
      case (cmd_code)
        CMD_AR_ON: begin
          ar_en_d = 1'b1;
          reload  = 1'b1;
        end
        CMD_AR_OFF: ar_en_d = 1'b0;
        CMD_SR_ENTER: begin
          sr_d  = 1'b1;
          flush = 1'b1;
        end
        CMD_SR_EXIT: begin
          if (sr_q) begin
            sr_d   = 1'b0;
            reload = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ar_en_q <= 1'b0;
      sr_q    <= 1'b0;
    end else if (mod_on) begin
      ar_en_q <= ar_en_d;
      sr_q    <= sr_d;
    end
  end

  assign ar_en    = ar_en_q;
  assign self_ref = sr_q;
endmodule

// File: rtl/srs_interval_timer.sv
module srs_interval_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mod_on,
  input  logic             run,
  input  logic             reload,
  input  logic [CNT_W-1:0] interval,
  output logic             due
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    due   = 1'b0;
    if (reload) begin
      cnt_d = interval;
    end else if (run) begin
      if (at_zero) begin
        cnt_d = interval;
        due   = mod_on;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (mod_on) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/srs_req_recovery.sv
module srs_req_recovery
  import srs_pkg::*;
#(
  parameter int REC_STEP = 3,
  localparam int REC_MAX = 3 * REC_STEP,
  localparam int REC_W   = $clog2(REC_MAX + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mod_on,
  input  logic       due,
  input  logic       ack,
  input  logic       flush,
  input  logic [1:0] recov_code,
  output logic       req,
  output logic       busy
);
  logic             req_q, req_d;
  logic [REC_W-1:0] rec_q, rec_d;
  logic             grant;

  assign grant = req_q && ack && !flush;

  always_comb begin
    req_d = req_q;
    rec_d = rec_q;
    if (flush)      req_d = 1'b0;
    else if (grant) req_d = 1'b0;
    else if (due)   req_d = 1'b1;
    if (grant)               rec_d = REC_W'(recov_len(recov_code, REC_STEP));
    else if (rec_q != '0)    rec_d = rec_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      rec_q <= '0;
    end else if (mod_on) begin
      req_q <= req_d;
      rec_q <= rec_d;
    end
  end

  assign req  = req_q;
  assign busy = req_q || (rec_q != '0);
endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched
  import srs_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int REC_STEP = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mod_on,
  input  logic [CNT_W-1:0] cfg_interval,
  input  logic [1:0]       cfg_recov,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_code,
  input  logic             refresh_ack,
  output logic             refresh_req,
  output logic             busy,
  output logic             self_ref
);
  logic ar_en, reload, flush, due, run;

  srs_cmd_decode u_dec (
    .clk(clk), .rst_n(rst_n), .mod_on(mod_on),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .ar_en(ar_en), .self_ref(self_ref), .reload(reload), .flush(flush)
  );

  assign run = ar_en && !self_ref;

  srs_interval_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .mod_on(mod_on), .run(run),
    .reload(reload), .interval(cfg_interval), .due(due)
  );

  srs_req_recovery #(.REC_STEP(REC_STEP)) u_rr (
    .clk(clk), .rst_n(rst_n), .mod_on(mod_on), .due(due),
    .ack(refresh_ack), .flush(flush), .recov_code(cfg_recov),
    .req(refresh_req), .busy(busy)
  );
endmodule

// File: rtl/srs_checker.sv
module srs_checker
  import srs_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       mod_on,
  input logic       cmd_valid,
  input logic [2:0] cmd_code,
  input logic       refresh_ack,
  input logic       refresh_req,
  input logic       busy,
  input logic       self_ref
);
  logic sr_enter_now;
  assign sr_enter_now = cmd_valid && (cmd_code == CMD_SR_ENTER);

  a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_on && refresh_req && !refresh_ack && !sr_enter_now) |=> refresh_req);

  a_r3_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_on && refresh_req && refresh_ack) |=> !refresh_req);

  a_r5_busy_cover: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req |-> busy);

  a_r5_busy_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_on && refresh_req && refresh_ack && !sr_enter_now) |=> busy);

  a_r7_sr_enter: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_on && sr_enter_now) |=> (self_ref && !refresh_req));

  a_r7_no_req_in_sr: assert property (@(posedge clk) disable iff (!rst_n)
    self_ref |-> !refresh_req);

  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_on |=> ($stable(refresh_req) && $stable(busy) && $stable(self_ref)));
endmodule

bind sdram_refresh_sched srs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .mod_on(mod_on), .cmd_valid(cmd_valid),
  .cmd_code(cmd_code), .refresh_ack(refresh_ack), .refresh_req(refresh_req),
  .busy(busy), .self_ref(self_ref)
);

// File: tb/sim_sdram_refresh_sched.sv
module sim_sdram_refresh_sched;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;

  logic             clk, rst_n, mod_on, cmd_valid, refresh_ack;
  logic [CNT_W-1:0] cfg_interval;
  logic [1:0]       cfg_recov;
  logic [2:0]       cmd_code;
  logic             refresh_req, busy, self_ref;

  int cyc, checks, errors;
  int t_cmd, t_r;
  logic done;

  sdram_refresh_sched #(.CNT_W(CNT_W), .REC_STEP(3)) u0 (
    .clk(clk), .rst_n(rst_n), .mod_on(mod_on), .cfg_interval(cfg_interval),
    .cfg_recov(cfg_recov), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .refresh_ack(refresh_ack), .refresh_req(refresh_req), .busy(busy),
    .self_ref(self_ref)
  );

  // {interval, recovery code, expected recovery clocks}
  localparam logic [25:0] VEC [5] = '{
    {16'd20, 2'd0, 8'd3},
    {16'd15, 2'd1, 8'd6},
    {16'd30, 2'd2, 8'd9},
    {16'd12, 2'd3, 8'd9},
    {16'd40, 2'd0, 8'd3}
  };

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [2:0] code);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_code  = code;
    t_cmd     = cyc;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_req(input int limit);
    for (int i = 0; i < limit && !refresh_req; i++) @(negedge clk);
  endtask

  task automatic grant();
    refresh_ack = 1'b1;
    @(negedge clk);
    refresh_ack = 1'b0;
  endtask

  initial begin
    done = 1'b0;
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, seen;
    cyc = 0; checks = 0; errors = 0;
    rst_n = 1'b0; mod_on = 1'b1; cmd_valid = 1'b0; cmd_code = 3'd0;
    refresh_ack = 1'b0; cfg_interval = 16'd20; cfg_recov = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 req", refresh_req, 0);
    check("R1 busy", busy, 0);
    check("R1 self_ref", self_ref, 0);

    // table of interval and recovery settings
    for (int v = 0; v < 5; v++) begin
      cfg_interval = VEC[v][25:10];
      cfg_recov    = VEC[v][9:8];
      send_cmd(3'd4);
      wait_req(200);
      check("R2 first latency", cyc - t_cmd, int'(VEC[v][25:10]) + 2);
      t_r = cyc;
      grant();
      check("R3 req drops on grant", refresh_req, 0);
      n = 0;
      while (busy && n < 50) begin n++; @(negedge clk); end
      check("R5 recovery length", n, int'(VEC[v][7:0]));
      wait_req(200);
      check("R2 period", cyc - t_r, int'(VEC[v][25:10]) + 1);
      grant();
      send_cmd(3'd5);
    end

    // R6: refresh off, no requests
    cfg_interval = 16'd12;
    seen = 0;
    for (int i = 0; i < 60; i++) begin @(negedge clk); seen += refresh_req; end
    check("R6 no req when off", seen, 0);

    // R10: unused codes and stray grant
    grant();
    check("R10 stray grant busy", busy, 0);
    send_cmd(3'd0); send_cmd(3'd1); send_cmd(3'd6); send_cmd(3'd7);
    seen = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); seen += refresh_req; end
    check("R10 unused codes no req", seen, 0);
    check("R10 unused codes self_ref", self_ref, 0);

    // R4: withheld grant across a second expiry
    cfg_interval = 16'd5; cfg_recov = 2'd0;
    send_cmd(3'd4);
    wait_req(100);
    repeat (8) @(negedge clk);
    check("R3 req held", refresh_req, 1);
    refresh_ack = 1'b1;
    @(negedge clk); refresh_ack = 1'b0;
    check("R4 no queued req +1", refresh_req, 0);
    @(negedge clk);
    check("R4 no queued req +2", refresh_req, 0);
    @(negedge clk);
    check("R4 no queued req +3", refresh_req, 0);
    @(negedge clk);
    check("R4 next interval req", refresh_req, 1);

    // R7: self-refresh entry withdraws pending request
    send_cmd(3'd2);
    check("R7 self_ref set", self_ref, 1);
    check("R7 pending withdrawn", refresh_req, 0);
    seen = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); seen += refresh_req; end
    check("R7 no req in self-refresh", seen, 0);

    // R8: exit restarts full interval
    cfg_interval = 16'd7;
    send_cmd(3'd3);
    check("R8 self_ref cleared", self_ref, 0);
    wait_req(100);
    check("R8 latency after exit", cyc - t_cmd, 9);
    grant();
    send_cmd(3'd5);
    repeat (12) @(negedge clk);

    // R9: module clock gated mid-interval
    cfg_interval = 16'd10;
    send_cmd(3'd4);
    repeat (4) @(negedge clk);
    mod_on = 1'b0; cmd_valid = 1'b1; cmd_code = 3'd2; refresh_ack = 1'b1;
    repeat (30) @(negedge clk);
    mod_on = 1'b1; cmd_valid = 1'b0; refresh_ack = 1'b0;
    check("R9 gated command ignored", self_ref, 0);
    check("R9 gated no req", refresh_req, 0);
    wait_req(100);
    check("R9 counter resumed", cyc - t_cmd, 42);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule